// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two counter tables give competing opinions. The global table is indexed by the lookup PC combined with a shift register that holds the outcomes of the most recent branches. The local table is indexed by the lookup PC combined with that branch's own recent outcomes, which a per-branch history table keeps. A per-PC arbiter counter picks which of the two opinions is driven out, and a flag reports which one was picked.

Resolved branches come back on the update port with their PC and actual direction. Each valid update trains both counter tables toward the outcome. It trains the arbiter only when one component was right and the other was wrong. It then shifts the outcome into both the global history and that branch's local history. The lookup side is purely combinational over the registered state. A lookup that shares a cycle with an update therefore sees the state from before that update.

Top module: `bp_tournament`

## Requirements
- R1: After reset every direction counter and every arbiter counter holds 1 (weakly not-taken, local selected), and all histories are zero, so any lookup gives pred_taken=0 and pred_src=0.
- R2: Each direction counter is 2 bits and saturates at 0 and 3; a value of 2 or 3 predicts taken. A taken update adds 1 and a not-taken update subtracts 1, so a settled prediction flips only after two wrong outcomes in a row.
- R3: The global table index is PC bits [5:2] XOR the 4-bit global history. Each valid update shifts the outcome into bit 0 of the global history, with older bits moving up one place.
- R4: A 16-entry local history table is indexed by PC bits [5:2]. The local table index is PC bits [5:2] XOR that branch's 4-bit local history. Each valid update shifts the outcome into bit 0 of the updated branch's local history only.
- R5: The arbiter holds one 2-bit counter per value of PC bits [5:2]. A value of 2 or more selects the global component (pred_src=1); otherwise the local component is selected (pred_src=0). pred_taken is the selected component's prediction.
- R6: On a valid update, the arbiter counter moves one step toward global when only the global component predicted the outcome correctly. It moves one step toward local when only the local component was correct. It is unchanged when both or neither were correct. It saturates at 0 and 3.
- R7: Predictions and correctness on the update side are computed from the state that existed before the update. A lookup in the same cycle as an update never sees that update.
- R8: When upd_valid is low, no table or history changes, whatever upd_pc and upd_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | PC of the branch being predicted |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| pred_taken | output | 1 | Predicted direction for lk_pc |
| pred_src | output | 1 | 1 when the global component was chosen, 0 for local |

## Verification
The predictor is driven with several kinds of branch behaviour:
- An always-taken branch shows saturation and the two-miss hysteresis.
- A branch that alternates its direction can only be learned through its local history.
- A pair of branches whose outcomes are correlated favours the global history and moves the arbiter.
- Updates held invalid while their other fields toggle must leave all state untouched.
- Lookups aimed at the PC being updated in the same cycle separate pre-update reads from post-update reads.
- A long random mix over several PCs that alias in the tables exercises the XOR indexing and arbiter training together.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'd1;
    localparam ctr_t CTR_MAX     = 2'd3;
    localparam ctr_t CTR_MIN     = 2'd0;

    // Saturating step of a 2-bit counter.
    function automatic ctr_t ctr_step(input ctr_t c, input logic up);
        ctr_t r;
        if (up) begin
            r = (c == CTR_MAX) ? CTR_MAX : ctr_t'(c + 2'd1);
        end else begin
            r = (c == CTR_MIN) ? CTR_MIN : ctr_t'(c - 2'd1);
        end
        return r;
    endfunction

    // Upper half of the counter range means taken (or global, for the arbiter).
    function automatic logic ctr_high(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter ctr_t INIT = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_en,
    input  logic             wr_up,
    output ctr_t             wr_ctr
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        ctr_t [ENTRIES-1:0] ent;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = ctr_step(st_q.ent[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.ent[i] <= INIT;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.ent[rd_idx];
    assign wr_ctr = st_q.ent[wr_idx];

endmodule

// File: rtl/bp_local_hist.sv
module bp_local_hist #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] wr_hist
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][HIST_W-1:0] h;
    } lht_t;

    lht_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (HIST_W > 1) begin
                st_d.h[wr_idx] = {st_q.h[wr_idx][HIST_W-2:0], wr_bit};
            end else begin
                st_d.h[wr_idx] = HIST_W'(wr_bit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hist = st_q.h[rd_idx];
    assign wr_hist = st_q.h[wr_idx];

endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int HIST_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            pred_taken,
    output logic            pred_src
);
    localparam int IDX_W = HIST_W;

    typedef struct packed {
        logic [HIST_W-1:0] ghr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [IDX_W-1:0]  l_pidx, u_pidx;
    logic [HIST_W-1:0] l_lh, u_lh;
    logic [HIST_W-1:0] ghr_q;
    logic [IDX_W-1:0]  g_rd_idx, l_rd_idx, g_wr_idx, l_wr_idx;
    ctr_t              g_rd_ctr, l_rd_ctr, ch_rd_ctr;
    ctr_t              g_upd_ctr, l_upd_ctr, ch_upd_ctr;
    logic              g_ok, l_ok, ch_en;

    assign l_pidx = lk_pc[PC_LSB +: IDX_W];
    assign u_pidx = upd_pc[PC_LSB +: IDX_W];
    assign ghr_q  = st_q.ghr;

    assign g_rd_idx = l_pidx ^ ghr_q;
    assign l_rd_idx = l_pidx ^ l_lh;
    assign g_wr_idx = u_pidx ^ ghr_q;
    assign l_wr_idx = u_pidx ^ u_lh;

    bp_local_hist #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (l_pidx),
        .rd_hist(l_lh),
        .wr_idx (u_pidx),
        .wr_en  (upd_valid),
        .wr_bit (upd_taken),
        .wr_hist(u_lh)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_gpht (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(g_rd_idx),
        .rd_ctr(g_rd_ctr),
        .wr_idx(g_wr_idx),
        .wr_en (upd_valid),
        .wr_up (upd_taken),
        .wr_ctr(g_upd_ctr)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_lpht (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(l_rd_idx),
        .rd_ctr(l_rd_ctr),
        .wr_idx(l_wr_idx),
        .wr_en (upd_valid),
        .wr_up (upd_taken),
        .wr_ctr(l_upd_ctr)
    );

    // Correctness of each component on the pre-update state.
    assign g_ok  = (ctr_high(g_upd_ctr) == upd_taken);
    assign l_ok  = (ctr_high(l_upd_ctr) == upd_taken);
    assign ch_en = upd_valid & (g_ok ^ l_ok);

    bp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_chooser (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(l_pidx),
        .rd_ctr(ch_rd_ctr),
        .wr_idx(u_pidx),
        .wr_en (ch_en),
        .wr_up (g_ok),
        .wr_ctr(ch_upd_ctr)
    );

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            if (HIST_W > 1) begin
                st_d.ghr = {st_q.ghr[HIST_W-2:0], upd_taken};
            end else begin
                st_d.ghr = HIST_W'(upd_taken);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_src   = ctr_high(ch_rd_ctr);
    assign pred_taken = pred_src ? ctr_high(g_rd_ctr) : ctr_high(l_rd_ctr);

endmodule

// File: rtl/bp_tournament_chk.sv
module bp_tournament_chk #(
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              pred_taken,
    input logic              pred_src,
    input logic [HIST_W-1:0] ghr_q,
    input logic [HIST_W-1:0] u_pidx,
    input logic [HIST_W-1:0] g_wr_idx,
    input logic [1:0]        g_upd_ctr,
    input logic [1:0]        ch_upd_ctr,
    input logic              g_ok,
    input logic              l_ok
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pred_taken && !pred_src));

    // R3
    ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr_q[0] == $past(upd_taken)) &&
                      (ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0])));

    // R8
    ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr_q));

    // R2
    ctr_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && upd_valid && (g_wr_idx == $past(g_wr_idx)) && $past(upd_taken))
        |-> (g_upd_ctr == (($past(g_upd_ctr) == 2'd3) ? 2'd3 : 2'($past(g_upd_ctr) + 2'd1))));

    // R6
    chooser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && upd_valid && (u_pidx == $past(u_pidx)) && $past(g_ok == l_ok))
        |-> (ch_upd_ctr == $past(ch_upd_ctr)));

    // R6
    chooser_toward_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && upd_valid && (u_pidx == $past(u_pidx)) && $past(g_ok && !l_ok))
        |-> (ch_upd_ctr == (($past(ch_upd_ctr) == 2'd3) ? 2'd3 : 2'($past(ch_upd_ctr) + 2'd1))));

endmodule

bind bp_tournament bp_tournament_chk #(.HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .pred_taken(pred_taken),
    .pred_src  (pred_src),
    .ghr_q     (ghr_q),
    .u_pidx    (u_pidx),
    .g_wr_idx  (g_wr_idx),
    .g_upd_ctr (g_upd_ctr),
    .ch_upd_ctr(ch_upd_ctr),
    .g_ok      (g_ok),
    .l_ok      (l_ok)
);

// File: tb/tb_bp_tournament.sv
module tb_bp_tournament;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pred_taken, pred_src;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bp_tournament dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .pred_taken(pred_taken), .pred_src(pred_src)
    );

    // Reference model written from the requirements.
    int m_g[16];
    int m_l[16];
    int m_c[16];
    int m_lh[16];
    int m_gh;

    bit   q_t[$];
    bit   q_s[$];
    string q_tag[$];

    function automatic int pidx(input logic [31:0] pc);
        return int'(pc[5:2]);
    endfunction

    function automatic int step_ctr(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_g[i] = 1; m_l[i] = 1; m_c[i] = 1; m_lh[i] = 0;
        end
        m_gh = 0;
    endtask

    task automatic model_update(input logic [31:0] pc, input bit t);
        int p, gi, li;
        bit gok, lok;
        p  = pidx(pc);
        gi = p ^ m_gh;
        li = p ^ m_lh[p];
        gok = ((m_g[gi] >= 2) == t);
        lok = ((m_l[li] >= 2) == t);
        m_g[gi] = step_ctr(m_g[gi], t);
        m_l[li] = step_ctr(m_l[li], t);
        if (gok && !lok) m_c[p] = step_ctr(m_c[p], 1'b1);
        if (lok && !gok) m_c[p] = step_ctr(m_c[p], 1'b0);
        m_gh    = ((m_gh << 1) | int'(t)) & 15;
        m_lh[p] = ((m_lh[p] << 1) | int'(t)) & 15;
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
    task automatic step(input logic [31:0] pc, input bit v, input logic [31:0] upc,
                        input bit t, input string tag);
        int p;
        bit src;
        @(negedge clk);
        lk_pc = pc; upd_valid = v; upd_pc = upc; upd_taken = t;
        p   = pidx(pc);
        src = (m_c[p] >= 2);
        q_s.push_back(src);
        q_t.push_back(src ? (m_g[p ^ m_gh] >= 2) : (m_l[p ^ m_lh[p]] >= 2));
        q_tag.push_back(tag);
        @(posedge clk);
        #1;
        if (v) model_update(upc, t);
    endtask

    // Monitor: compares design outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        #5;
        while (q_t.size() > 0) begin
            bit et, es;
            string tg;
            et = q_t.pop_front();
            es = q_s.pop_front();
            tg = q_tag.pop_front();
            n_checks++;
            if (pred_taken !== et) begin
                n_errors++;
                $display("FAIL %s pred_taken actual=%b expected=%b", tg, pred_taken, et);
            end
            n_checks++;
            if (pred_src !== es) begin
                n_errors++;
                $display("FAIL %s pred_src actual=%b expected=%b", tg, pred_src, es);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [31:0] PC_A = 32'h0000_1004;
    localparam logic [31:0] PC_B = 32'h0000_2018;
    localparam logic [31:0] PC_C = 32'h0000_3020;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across several PCs
        for (int i = 0; i < 16; i++) step(32'(i * 4), 1'b0, '0, 1'b0, "R1");

        // R8: invalid updates with busy fields change nothing
        for (int i = 0; i < 8; i++) step(PC_A, 1'b0, PC_A, 1'b1, "R8");
        step(PC_A, 1'b0, '0, 1'b0, "R8");

        // R2: always-taken branch saturates, then two misses flip it back
        for (int i = 0; i < 10; i++) step(PC_A, 1'b1, PC_A, 1'b1, "R2");
        step(PC_A, 1'b1, PC_A, 1'b0, "R2");
        step(PC_A, 1'b1, PC_A, 1'b0, "R2");
        step(PC_A, 1'b0, '0, 1'b0, "R2");

        // R4: alternating branch is learned through local history
        for (int i = 0; i < 24; i++) step(PC_B, 1'b1, PC_B, (i % 2) == 0, "R4");

        // R3 and R5: correlated pair, second copies first
        for (int i = 0; i < 30; i++) begin
            bit o;
            o = ((i / 3) % 2) == 0;
            step(PC_C, 1'b1, PC_A, o, "R3");
            step(PC_C, 1'b1, PC_C, o, "R5");
        end

        // R7: lookup of the very PC being updated in the same cycle
        for (int i = 0; i < 12; i++) step(PC_B, 1'b1, PC_B, 1'b1, "R7");

        // R6: random mix over aliasing PCs trains the arbiter both ways
        for (int i = 0; i < 400; i++) begin
            logic [31:0] lp, up;
            bit v, t;
            lp = 32'({$urandom_range(0, 5)} * 32'h44);
            up = 32'({$urandom_range(0, 5)} * 32'h44);
            v  = ($urandom_range(0, 3) != 0);
            t  = ($urandom_range(0, 2) != 0);
            step(lp, v, up, t, "R6");
        end

        @(negedge clk);
        #8;
        finish_run();
    end

endmodule